// File: doc/BRIEF.md
# Resonant-Mode Switching Pulse Timer

This block produces one gate pulse per switching cycle of a resonant power stage. Every clock is one timing tick; in the intended system, one tick is 5 ns. At each cycle start the block takes the period requested by the control loop. It raises that period to a programmable minimum-cycle limit, which caps the switching frequency. It then runs a counter over the resulting effective cycle.

The pulse rises a programmed number of ticks after cycle start. It falls at a signed tick offset from the cycle midpoint, which can lead or trail that point. The timing settings come from a small byte-wide register port with combinational readback. Every setting, and the requested period, is copied into shadow state only at a cycle start. A register write or a period change in mid-cycle therefore never disturbs the cycle already under way.

All pins are plain control and status signals. The period input is a level that is sampled and never handshaken, so there is no back-pressure at any edge of the block.

Top module: `pwmr_edge_timer`

## Requirements
- R1: The effective cycle length in ticks is the larger of `period_i` and the minimum-cycle limit, and never less than 1. Consecutive `cyc_start_o` pulses are exactly that many clocks apart.
- R2: The minimum-cycle limit is a 12-bit tick count. Its upper eight bits are register 2. Its lower four bits are bits [7:4] of register 3. The limit is therefore reg2×16 + reg3[7:4].
- R3: Register 0 is an unsigned rising delay D. The pulse is high from the tick where the cycle counter equals D, counting the start tick as tick 0.
- R4: Register 1 is a two's-complement signed offset O. Values 0x00 to 0x7F mean 0 to +127 ticks (trailing), and values 0x80 to 0xFF mean -128 to -1 ticks (leading). The falling tick is floor(period/2) + O. The pulse is low from that tick onward.
- R5: The falling tick is clamped to the range 0 to period−1.
- R6: When the falling tick is at or before the rising tick, the pulse stays low for the whole cycle.
- R7: Register values and `period_i` take effect only at the next cycle start. A write during a cycle leaves that cycle's length and pulse unchanged.
- R8: While `en_i` is low, `pulse_o` is low at once. From the next clock on, the counter is held at zero and no `cyc_start_o` is issued.
- R9: `cyc_start_o` is high for one clock as the counter wraps to zero. The first pulse comes on the first clock edge at which `en_i` is high.
- R10: After reset all registers read as zero. Reads return the written values, and bits [3:0] of register 3 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Run enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 8 | Register read data (combinational) |
| period_i | input | PER_W | Requested cycle length in ticks |
| cyc_start_o | output | 1 | One-clock cycle-start strobe |
| pulse_o | output | 1 | Gate pulse output |

## Verification
The bench builds the block with the default PER_W of 12. This lets the full 12-bit minimum-cycle limit act on the period, including the example limit of 265 ticks together with the largest rising delay of 255. Requested periods of up to 300 ticks are used, so offsets of -128 and +127 land both inside the cycle and past either clamp. Every cycle's length and its tick-by-tick pulse shape are compared against a queue filled by the configuration driver. The driver rewrites the configuration during the last cycle of the previous one, which exercises the shadowing rule.

// File: rtl/pwmr_pkg.sv
package pwmr_pkg;
  localparam int FLD_W = 8;
  localparam int NIB_W = 4;
  localparam int LIM_W = FLD_W + NIB_W;

  typedef enum logic [1:0] {
    A_RISE  = 2'd0,
    A_FOFS  = 2'd1,
    A_LIMHI = 2'd2,
    A_LIMLO = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/pwmr_regs.sv
module pwmr_regs
  import pwmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [FLD_W-1:0] wr_data_i,
  input  logic [1:0]       rd_addr_i,
  output logic [FLD_W-1:0] rd_data_o,
  output logic [FLD_W-1:0] rise_o,
  output logic [FLD_W-1:0] fofs_o,
  output logic [LIM_W-1:0] lim_o
);
  logic [FLD_W-1:0] rise_q, fofs_q, limhi_q;
  logic [NIB_W-1:0] limlo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q  <= '0;
      fofs_q  <= '0;
      limhi_q <= '0;
      limlo_q <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_RISE:  rise_q  <= wr_data_i;
        A_FOFS:  fofs_q  <= wr_data_i;
        A_LIMHI: limhi_q <= wr_data_i;
        default: limlo_q <= wr_data_i[FLD_W-1 -: NIB_W];
      endcase
    end
  end

  always_comb begin
    case (rd_addr_i)
      A_RISE:  rd_data_o = rise_q;
      A_FOFS:  rd_data_o = fofs_q;
      A_LIMHI: rd_data_o = limhi_q;
      default: rd_data_o = {limlo_q, {(FLD_W-NIB_W){1'b0}}};
    endcase
  end

  assign rise_o = rise_q;
  assign fofs_o = fofs_q;
  assign lim_o  = {limhi_q, limlo_q};

  // R10
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_i == A_LIMLO) |-> (rd_data_o[NIB_W-1:0] == '0));

  // R2
  lim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(lim_o));
endmodule

// File: rtl/pwmr_plan.sv
module pwmr_plan
  import pwmr_pkg::*;
#(
  parameter int PER_W = 12
) (
  input  logic [PER_W-1:0] req_i,
  input  logic [LIM_W-1:0] lim_i,
  input  logic [FLD_W-1:0] fofs_i,
  output logic [PER_W-1:0] eff_o,
  output logic [PER_W-1:0] fall_o
);
  localparam int SW = PER_W + 2;

  logic [PER_W-1:0]     lim_ext, big, mid;
  logic signed [SW-1:0] sum, eff_s;

  always_comb begin
    lim_ext = PER_W'(lim_i);
    big     = (req_i > lim_ext) ? req_i : lim_ext;
    eff_o   = (big == '0) ? PER_W'(1) : big;
    mid     = eff_o >> 1;
    eff_s   = $signed({2'b00, eff_o});
    sum     = $signed({2'b00, mid}) + SW'($signed(fofs_i));
    if (sum < 0)
      fall_o = '0;
    else if (sum >= eff_s)
      fall_o = eff_o - PER_W'(1);
    else
      fall_o = sum[PER_W-1:0];
  end
endmodule

// File: rtl/pwmr_seq.sv
module pwmr_seq
  import pwmr_pkg::*;
#(
  parameter int PER_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [PER_W-1:0] eff_i,
  input  logic [PER_W-1:0] fall_i,
  input  logic [FLD_W-1:0] rise_i,
  input  logic [LIM_W-1:0] lim_i,
  output logic             cyc_start_o,
  output logic             pulse_o
);
  logic             run_q, start_q, load;
  logic [PER_W-1:0] cnt_q, per_q, fall_q;
  logic [FLD_W-1:0] rise_q;

  assign load = en_i && (!run_q || (cnt_q == per_q - PER_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      start_q <= 1'b0;
      cnt_q   <= '0;
      per_q   <= '0;
      fall_q  <= '0;
      rise_q  <= '0;
    end else if (!en_i) begin
      run_q   <= 1'b0;
      start_q <= 1'b0;
      cnt_q   <= '0;
    end else if (load) begin
      run_q   <= 1'b1;
      start_q <= 1'b1;
      cnt_q   <= '0;
      per_q   <= eff_i;
      fall_q  <= fall_i;
      rise_q  <= rise_i;
    end else begin
      start_q <= 1'b0;
      cnt_q   <= cnt_q + PER_W'(1);
    end
  end

  assign cyc_start_o = start_q;
  assign pulse_o = run_q && en_i && (cnt_q >= PER_W'(rise_q)) && (cnt_q < fall_q);

  // R9
  start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start_o |-> (run_q && cnt_q == '0));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!run_q && cnt_q == '0 && !cyc_start_o));

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q < per_q));

  // R1
  clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (per_q >= PER_W'($past(lim_i)) && per_q != '0));

  // R5
  fall_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (fall_q < per_q));

  // R7
  shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && en_i && !load) |=> ($stable(per_q) && $stable(rise_q) && $stable(fall_q)));
endmodule

// File: rtl/pwmr_edge_timer.sv
module pwmr_edge_timer
  import pwmr_pkg::*;
#(
  parameter int PER_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [7:0]       wr_data_i,
  input  logic [1:0]       rd_addr_i,
  output logic [7:0]       rd_data_o,
  input  logic [PER_W-1:0] period_i,
  output logic             cyc_start_o,
  output logic             pulse_o
);
  logic [FLD_W-1:0] rise_w, fofs_w;
  logic [LIM_W-1:0] lim_w;
  logic [PER_W-1:0] eff_w, fall_w;

  pwmr_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .rise_o    (rise_w),
    .fofs_o    (fofs_w),
    .lim_o     (lim_w)
  );

  pwmr_plan #(.PER_W(PER_W)) u_plan (
    .req_i  (period_i),
    .lim_i  (lim_w),
    .fofs_i (fofs_w),
    .eff_o  (eff_w),
    .fall_o (fall_w)
  );

  pwmr_seq #(.PER_W(PER_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .eff_i       (eff_w),
    .fall_i      (fall_w),
    .rise_i      (rise_w),
    .lim_i       (lim_w),
    .cyc_start_o (cyc_start_o),
    .pulse_o     (pulse_o)
  );
endmodule

// File: tb/sim_pwmr_edge_timer.sv
module sim_pwmr_edge_timer;
  localparam int PER_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en_i = 1'b0;
  logic             wr_en_i = 1'b0;
  logic [1:0]       wr_addr_i = '0;
  logic [7:0]       wr_data_i = '0;
  logic [1:0]       rd_addr_i = '0;
  logic [7:0]       rd_data_o;
  logic [PER_W-1:0] period_i = '0;
  logic             cyc_start_o, pulse_o;

  always #4 clk = ~clk;

  pwmr_edge_timer #(.PER_W(PER_W)) u0 (.*);

  typedef struct {
    int    per;
    int    rise;
    int    fall;
    string tag;
  } item_t;

  item_t q[$];
  item_t cur;
  int    total = 0, fails = 0;
  bit    mon_on = 1'b0, have = 1'b0, shape_ok = 1'b1, done = 1'b0;
  int    k = 0, bad_k = 0, bad_v = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: one length check and one shape check per cycle
  always @(negedge clk) begin
    if (mon_on) begin
      if (cyc_start_o) begin
        if (have) begin
          check(k == cur.per, {cur.tag, " R1 R9 cycle length"}, k, cur.per);
          check(shape_ok, {cur.tag, " R3 R4 R6 R7 pulse shape at tick"}, bad_v, bad_k);
        end
        if (q.size() > 0) begin
          cur = q.pop_front();
          have = 1'b1;
        end else begin
          have = 1'b0;
        end
        k = 0;
        shape_ok = 1'b1;
      end
      if (have) begin
        if (pulse_o != ((k >= cur.rise) && (k < cur.fall)) && shape_ok) begin
          shape_ok = 1'b0;
          bad_k = k;
          bad_v = pulse_o;
        end
        k++;
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    rd_addr_i = a;
    #1;
    check(rd_data_o == exp, tag, rd_data_o, exp);
  endtask

  function automatic int calc_fall(input int per, input int off8);
    int o = (off8 > 127) ? off8 - 256 : off8;
    int f = per / 2 + o;
    if (f < 0) f = 0;
    if (f > per - 1) f = per - 1;
    return f;
  endfunction

  // Driver: program a configuration and push its expected cycles
  task automatic cfg(input int rise, input int off, input int hi, input int lo,
                     input int req, input int n, input string tag);
    item_t it;
    int lim = hi * 16 + (lo >> 4);
    int eff = (req > lim) ? req : lim;
    if (eff < 1) eff = 1;
    wr(2'd0, 8'(rise));
    wr(2'd1, 8'(off));
    wr(2'd2, 8'(hi));
    wr(2'd3, 8'(lo));
    period_i = PER_W'(req);
    it.per = eff; it.rise = rise; it.fall = calc_fall(eff, off); it.tag = tag;
    for (int i = 0; i < n; i++) q.push_back(it);
  endtask

  task automatic wait_starts(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!cyc_start_o) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(pulse_o == 1'b0 && cyc_start_o == 1'b0, "R8 reset outputs low", pulse_o, 0);
    rst_n = 1'b1;
    for (int a = 0; a < 4; a++) rd(2'(a), 8'h00, "R10 reset readback");

    cfg(4, 8'h00, 0, 0, 40, 3, "basic");
    rd(2'd3, 8'h00, "R10 limit nibble");
    mon_on = 1'b1;
    @(negedge clk);
    en_i = 1'b1;
    @(negedge clk);
    check(cyc_start_o == 1'b1, "R9 first start after enable", cyc_start_o, 1);
    wait_starts(2);
    cfg(2, 8'h03, 2, 8'h3F, 20, 3, "R2 limit clamp");
    rd(2'd3, 8'h30, "R10 reserved bits zero");
    rd(2'd2, 8'h02, "R10 upper limit readback");
    wait_starts(3);
    cfg(10, 8'h80, 0, 0, 300, 3, "R4 leading -128");
    rd(2'd1, 8'h80, "R10 offset readback");
    wait_starts(3);
    cfg(30, 8'hFB, 0, 0, 40, 3, "R6 fall before rise");
    wait_starts(3);
    cfg(0, 8'h7F, 0, 0, 40, 3, "R5 clamp high");
    wait_starts(3);
    cfg(0, 8'h80, 0, 0, 40, 3, "R5 clamp low");
    wait_starts(3);
    cfg(5, 8'h10, 2, 8'h30, 50, 3, "R1 request above limit");
    wait_starts(3);
    cfg(255, 8'h7F, 8'h10, 8'h9A, 100, 2, "R2 R3 limit 265");
    wait_starts(2);
    wait_starts(1);
    mon_on = 1'b0;

    // R8: disable in the middle of a pulse
    while (!pulse_o) @(negedge clk);
    en_i = 1'b0;
    #1;
    check(pulse_o == 1'b0, "R8 pulse drops with enable", pulse_o, 0);
    begin
      bit quiet = 1'b1;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (pulse_o || cyc_start_o) quiet = 1'b0;
      end
      check(quiet, "R8 no activity while disabled", !quiet, 0);
    end
    en_i = 1'b1;
    @(negedge clk);
    check(cyc_start_o == 1'b1, "R9 restart after enable", cyc_start_o, 1);
    @(negedge clk);
    check(cyc_start_o == 1'b0, "R9 strobe one clock", cyc_start_o, 0);
    en_i = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule